// File: doc/BRIEF.md
# Peer Control Message Parser

This block takes a byte stream of control messages sent by a coordinating server. For each peer it keeps a count of the notification vectors that peer has registered. Bytes are collected in a small frame buffer. Each message opens with a little-endian header that gives a message type and the total message length. When a whole message is in the buffer, the block checks it, updates the per-peer counts, and either stays silent, reports an error code, or raises a peer-gone event.

The surrounding logic sets the largest number of vectors a peer may hold and the local node's own peer ID. It reads any peer's vector count through a combinational read port. It watches a one-cycle error strobe with a code, and a one-cycle peer-gone strobe that carries the departed peer's ID and asks the node for a local vector-0 event. The peer table has a fixed size. The tracked peer range starts at zero after reset and only grows, when connect messages name new peers.

Top module: `pcp_ctrl_parser`

## Requirements
- R1: After reset every vector count reads zero, the tracked peer range is zero, in_ready_o is high and neither strobe is asserted.
- R2: The frame buffer holds 32 bytes. in_ready_o is high exactly while fewer than 32 bytes are held, and a byte is taken on a clock edge where in_valid_i and in_ready_o are both high.
- R3: Byte offsets 0..3 hold the type and offsets 4..7 hold the total length, both least significant byte first. A message is handled once at least 8 bytes and at least its length are buffered. Exactly that length is then removed, and the bytes after it are kept in order for the next message.
- R4: A connect message is type 1 with a minimum length of 16. Offsets 8..11 hold the peer ID and offsets 12..15 hold the vector index, both little-endian. It is accepted when the vector index equals the peer's current count and the count is below vec_limit_i. The count then rises by one and no strobe is raised.
- R5: A connect whose vector index differs from the peer's current count raises error code 2 and leaves the count unchanged.
- R6: A connect whose index is in order but whose peer already holds vec_limit_i vectors raises error code 3 and leaves the count unchanged.
- R7: A peer-gone message is type 2 with a minimum length of 12, and offsets 8..11 hold the peer ID. For a peer inside the tracked range that is not own_id_i, it clears that peer's count and pulses gone_o for one cycle, with gone_peer_o set to that ID.
- R8: A peer-gone naming an ID at or above the tracked range, or equal to own_id_i, raises error code 4 and changes no count.
- R9: A connect with a peer ID below 16 and at or above the tracked range grows the range to ID+1, even when the connect is then rejected. A connect with an ID of 16 or more raises error code 4.
- R10: Error code 1 is raised in three cases. A declared length between 8 and 32 that is below the type's minimum removes that many bytes. A length below 8 removes 8 bytes. A length above 32 removes all 32 buffered bytes once the buffer is full.
- R11: Any type other than 1 or 2, with a length from 8 to 32, raises error code 5 and removes the declared length.
- R12: Each handled message gives at most one one-cycle strobe, err_o or gone_o, never both. err_code_o then holds 1 (size), 2 (order), 3 (too many vectors), 4 (invalid peer) or 5 (unknown type).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Stream byte |
| in_valid_i | input | 1 | Stream byte valid |
| in_ready_o | output | 1 | Frame buffer has free space |
| vec_limit_i | input | CNT_W (11) | Maximum vectors per peer |
| own_id_i | input | PEER_W (4) | Local peer ID |
| rd_peer_i | input | PEER_W (4) | Peer selected on the read port |
| rd_count_o | output | CNT_W (11) | Vector count of the selected peer |
| err_o | output | 1 | One-cycle error strobe |
| err_code_o | output | 3 | Error code, valid with err_o |
| gone_o | output | 1 | One-cycle peer-gone strobe (local vector-0 event) |
| gone_peer_o | output | PEER_W (4) | Departed peer ID, valid with gone_o |

## Verification
Connect messages go to one peer in order, then repeat an index and then reach the vector limit. This separates the order check from the limit check and shows which one wins when both could apply. Peer-gone messages name peers below the range, above it, just grown into it, and the node itself, so range tracking and the own-ID guard are tested apart. Messages are sent back to back with declared lengths below the minimum, above the minimum with padding, below the header size, and above the buffer size. Each is followed at once by a valid message, so a wrong byte count on removal shows up as a garbled next message. A non-connect type is also sent.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
  localparam int unsigned HDR_BYTES     = 8;
  localparam int unsigned CONNECT_BYTES = 16;
  localparam int unsigned GONE_BYTES    = 12;
  localparam int unsigned WIN_BYTES     = 16;
  localparam logic [31:0] MSG_CONNECT   = 32'd1;
  localparam logic [31:0] MSG_GONE      = 32'd2;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_SIZE  = 3'd1,
    ERR_ORDER = 3'd2,
    ERR_FULL  = 3'd3,
    ERR_PEER  = 3'd4,
    ERR_TYPE  = 3'd5
  } err_e;
endpackage

// File: rtl/pcp_frame_buf.sv
module pcp_frame_buf #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned WIN    = 16,
  parameter int unsigned FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [7:0]        byte_i,
  input  logic              pop_i,
  input  logic [FILL_W-1:0] pop_len_i,
  output logic [FILL_W-1:0] fill_o,
  output logic [WIN*8-1:0]  win_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [7:0]        mem_q [DEPTH];
  logic [7:0]        mem_d [DEPTH];
  logic [FILL_W-1:0] fill_q, fill_d;

  // shift out consumed bytes and append the new one in the same cycle
  always_comb begin
    int c;
    int base;
    c    = pop_i ? int'(pop_len_i) : 0;
    base = int'(fill_q) - c;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (i + c < int'(DEPTH)) mem_d[i] = mem_q[AW'(i + c)];
      else                     mem_d[i] = '0;
      if (push_i && i == base) mem_d[i] = byte_i;
    end
    fill_d = FILL_W'(base + (push_i ? 1 : 0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else begin
      fill_q <= fill_d;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= mem_d[i];
    end
  end

  assign fill_o = fill_q;

  for (genvar k = 0; k < int'(WIN); k++) begin : g_win
    assign win_o[k*8 +: 8] = mem_q[k];
  end
endmodule

// File: rtl/pcp_decode.sv
module pcp_decode
  import pcp_pkg::*;
#(
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned NUM_PEERS = 16,
  parameter int unsigned CNT_W     = 11,
  parameter int unsigned FILL_W    = $clog2(DEPTH + 1),
  parameter int unsigned PEER_W    = $clog2(NUM_PEERS),
  parameter int unsigned TRK_W     = $clog2(NUM_PEERS + 1)
) (
  input  logic [WIN_BYTES*8-1:0] win_i,
  input  logic [FILL_W-1:0]      fill_i,
  input  logic [TRK_W-1:0]       tracked_i,
  input  logic [CNT_W-1:0]       peer_cnt_i,
  input  logic [CNT_W-1:0]       vec_limit_i,
  input  logic [PEER_W-1:0]      own_id_i,
  output logic                   proc_o,
  output logic [FILL_W-1:0]      pop_len_o,
  output logic [PEER_W-1:0]      peer_idx_o,
  output logic                   inc_o,
  output logic                   clr_o,
  output logic                   grow_o,
  output logic                   gone_o,
  output err_e                   err_o
);
  logic [31:0] msg_type, msg_len, msg_id, msg_vec, need;

  assign msg_type = win_i[31:0];
  assign msg_len  = win_i[63:32];
  assign msg_id   = win_i[95:64];
  assign msg_vec  = win_i[127:96];

  always_comb begin
    if (msg_len < HDR_BYTES)  need = HDR_BYTES;
    else if (msg_len > DEPTH) need = DEPTH;
    else                      need = msg_len;
  end

  assign proc_o     = 32'(fill_i) >= need;
  assign pop_len_o  = FILL_W'(need);
  assign peer_idx_o = msg_id[PEER_W-1:0];

  always_comb begin
    err_o  = ERR_NONE;
    inc_o  = 1'b0;
    clr_o  = 1'b0;
    grow_o = 1'b0;
    gone_o = 1'b0;
    if (msg_len < HDR_BYTES || msg_len > DEPTH) begin
      err_o = ERR_SIZE;
    end else if (msg_type == MSG_CONNECT) begin
      if (msg_len < CONNECT_BYTES)       err_o = ERR_SIZE;
      else if (msg_id >= NUM_PEERS)      err_o = ERR_PEER;
      else begin
        grow_o = msg_id >= 32'(tracked_i);
        if (msg_vec != 32'(peer_cnt_i))     err_o = ERR_ORDER;
        else if (peer_cnt_i >= vec_limit_i) err_o = ERR_FULL;
        else                                inc_o = 1'b1;
      end
    end else if (msg_type == MSG_GONE) begin
      if (msg_len < GONE_BYTES) err_o = ERR_SIZE;
      else if (msg_id >= 32'(tracked_i) || msg_id == 32'(own_id_i)) err_o = ERR_PEER;
      else begin
        clr_o  = 1'b1;
        gone_o = 1'b1;
      end
    end else begin
      err_o = ERR_TYPE;
    end
    if (!proc_o) begin
      err_o  = ERR_NONE;
      inc_o  = 1'b0;
      clr_o  = 1'b0;
      grow_o = 1'b0;
      gone_o = 1'b0;
    end
  end
endmodule

// File: rtl/pcp_peer_table.sv
module pcp_peer_table #(
  parameter int unsigned NUM_PEERS = 16,
  parameter int unsigned CNT_W     = 11,
  parameter int unsigned PEER_W    = $clog2(NUM_PEERS),
  parameter int unsigned TRK_W     = $clog2(NUM_PEERS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [PEER_W-1:0]          idx_i,
  input  logic                       inc_i,
  input  logic                       clr_i,
  input  logic                       grow_i,
  input  logic [PEER_W-1:0]          rd_idx_i,
  output logic [CNT_W-1:0]           lk_cnt_o,
  output logic [CNT_W-1:0]           rd_cnt_o,
  output logic [TRK_W-1:0]           tracked_o,
  output logic [NUM_PEERS*CNT_W-1:0] cnt_flat_o
);
  logic [CNT_W-1:0] cnt_q [NUM_PEERS];
  logic [TRK_W-1:0] trk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trk_q <= '0;
      for (int e = 0; e < int'(NUM_PEERS); e++) cnt_q[e] <= '0;
    end else begin
      if (grow_i) trk_q <= TRK_W'(idx_i) + TRK_W'(1);
      for (int e = 0; e < int'(NUM_PEERS); e++) begin
        if (idx_i == PEER_W'(e)) begin
          if (clr_i)      cnt_q[e] <= '0;
          else if (inc_i) cnt_q[e] <= cnt_q[e] + CNT_W'(1);
        end
      end
    end
  end

  assign lk_cnt_o  = cnt_q[idx_i];
  assign rd_cnt_o  = cnt_q[rd_idx_i];
  assign tracked_o = trk_q;

  for (genvar g = 0; g < int'(NUM_PEERS); g++) begin : g_flat
    assign cnt_flat_o[g*CNT_W +: CNT_W] = cnt_q[g];
  end
endmodule

// File: rtl/pcp_ctrl_parser.sv
module pcp_ctrl_parser
  import pcp_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 32,
  parameter int unsigned NUM_PEERS = 16,
  parameter int unsigned CNT_W     = 11,
  localparam int unsigned PEER_W   = $clog2(NUM_PEERS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [CNT_W-1:0]  vec_limit_i,
  input  logic [PEER_W-1:0] own_id_i,
  input  logic [PEER_W-1:0] rd_peer_i,
  output logic [CNT_W-1:0]  rd_count_o,
  output logic              err_o,
  output logic [2:0]        err_code_o,
  output logic              gone_o,
  output logic [PEER_W-1:0] gone_peer_o
);
  localparam int unsigned FILL_W = $clog2(BUF_BYTES + 1);
  localparam int unsigned TRK_W  = $clog2(NUM_PEERS + 1);

  logic [FILL_W-1:0]          fill;
  logic [WIN_BYTES*8-1:0]     win;
  logic                       push, proc, inc, clr, grow, gone_evt;
  logic [FILL_W-1:0]          pop_len;
  logic [PEER_W-1:0]          peer_idx;
  logic [CNT_W-1:0]           lk_cnt;
  logic [TRK_W-1:0]           tracked;
  logic [NUM_PEERS*CNT_W-1:0] cnt_flat;
  err_e                       dec_err;

  assign in_ready_o = fill < FILL_W'(BUF_BYTES);
  assign push       = in_valid_i && in_ready_o;

  pcp_frame_buf #(.DEPTH(BUF_BYTES), .WIN(WIN_BYTES), .FILL_W(FILL_W)) u_buf (
    .clk_i, .rst_ni,
    .push_i   (push),
    .byte_i   (in_data_i),
    .pop_i    (proc),
    .pop_len_i(pop_len),
    .fill_o   (fill),
    .win_o    (win)
  );

  pcp_decode #(
    .DEPTH(BUF_BYTES), .NUM_PEERS(NUM_PEERS), .CNT_W(CNT_W),
    .FILL_W(FILL_W), .PEER_W(PEER_W), .TRK_W(TRK_W)
  ) u_dec (
    .win_i      (win),
    .fill_i     (fill),
    .tracked_i  (tracked),
    .peer_cnt_i (lk_cnt),
    .vec_limit_i(vec_limit_i),
    .own_id_i   (own_id_i),
    .proc_o     (proc),
    .pop_len_o  (pop_len),
    .peer_idx_o (peer_idx),
    .inc_o      (inc),
    .clr_o      (clr),
    .grow_o     (grow),
    .gone_o     (gone_evt),
    .err_o      (dec_err)
  );

  pcp_peer_table #(
    .NUM_PEERS(NUM_PEERS), .CNT_W(CNT_W), .PEER_W(PEER_W), .TRK_W(TRK_W)
  ) u_tab (
    .clk_i, .rst_ni,
    .idx_i     (peer_idx),
    .inc_i     (inc),
    .clr_i     (clr),
    .grow_i    (grow),
    .rd_idx_i  (rd_peer_i),
    .lk_cnt_o  (lk_cnt),
    .rd_cnt_o  (rd_count_o),
    .tracked_o (tracked),
    .cnt_flat_o(cnt_flat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o       <= 1'b0;
      err_code_o  <= '0;
      gone_o      <= 1'b0;
      gone_peer_o <= '0;
    end else begin
      err_o       <= dec_err != ERR_NONE;
      err_code_o  <= dec_err;
      gone_o      <= gone_evt;
      gone_peer_o <= peer_idx;
    end
  end
endmodule

// File: rtl/pcp_ctrl_parser_chk.sv
module pcp_ctrl_parser_chk #(
  parameter int unsigned BUF_BYTES = 32,
  parameter int unsigned NUM_PEERS = 16,
  parameter int unsigned CNT_W     = 11,
  parameter int unsigned PEER_W    = $clog2(NUM_PEERS),
  parameter int unsigned FILL_W    = $clog2(BUF_BYTES + 1)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       err_o,
  input logic [2:0]                 err_code_o,
  input logic                       gone_o,
  input logic [PEER_W-1:0]          gone_peer_o,
  input logic [PEER_W-1:0]          own_id_i,
  input logic [FILL_W-1:0]          fill,
  input logic [NUM_PEERS*CNT_W-1:0] cnt_flat
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= FILL_W'(BUF_BYTES)); // R2

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && gone_o)); // R12

  AST_ERR_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_code_o >= 3'd1 && err_code_o <= 3'd5)); // R12

  AST_GONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gone_o |-> cnt_flat[gone_peer_o*CNT_W +: CNT_W] == '0); // R7

  AST_GONE_NOT_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gone_o |-> gone_peer_o != $past(own_id_i)); // R8
endmodule

bind pcp_ctrl_parser pcp_ctrl_parser_chk #(
  .BUF_BYTES(BUF_BYTES), .NUM_PEERS(NUM_PEERS), .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .err_o      (err_o),
  .err_code_o (err_code_o),
  .gone_o     (gone_o),
  .gone_peer_o(gone_peer_o),
  .own_id_i   (own_id_i),
  .fill       (fill),
  .cnt_flat   (cnt_flat)
);

// File: tb/pcp_ctrl_parser_tb_top.sv
`timescale 1ns/1ps
module pcp_ctrl_parser_tb_top;
  localparam int LIM = 3;
  localparam int OWN = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [10:0] vec_limit = 11'(LIM);
  logic [3:0]  own_id = 4'(OWN);
  logic [3:0]  rd_peer = '0;
  logic [10:0] rd_count;
  logic        err, gone;
  logic [2:0]  err_code;
  logic [3:0]  gone_peer;

  typedef struct {
    bit    is_gone;
    int    code;
    int    peer;
    string tag;
  } ev_t;

  ev_t sb[$];
  int  n_cmp = 0;
  int  n_mis = 0;
  int  m_cnt[16];
  int  m_trk = 0;

  always #5 clk = ~clk;

  pcp_ctrl_parser dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .vec_limit_i(vec_limit), .own_id_i(own_id),
    .rd_peer_i(rd_peer), .rd_count_o(rd_count),
    .err_o(err), .err_code_o(err_code),
    .gone_o(gone), .gone_peer_o(gone_peer)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: every strobe must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && (err || gone)) begin
      if (sb.size() == 0) begin
        n_cmp++; n_mis++;
        $display("FAIL R12: unexpected strobe err=%0d code=%0d gone=%0d peer=%0d, expected none",
                 err, err_code, gone, gone_peer);
      end else begin
        ev_t e;
        e = sb.pop_front();
        if (e.is_gone) check(gone && !err && gone_peer == 4'(e.peer), e.tag, int'(gone_peer), e.peer);
        else           check(err && !gone && err_code == 3'(e.code), e.tag, int'(err_code), e.code);
      end
    end
  end

  task automatic exp_err(input int code, input string tag);
    ev_t e;
    e.is_gone = 1'b0; e.code = code; e.peer = 0; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic exp_gone(input int peer, input string tag);
    ev_t e;
    e.is_gone = 1'b1; e.code = 0; e.peer = peer; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    in_data  = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_msg(input int typ, input int len, input int id, input int vec, input int nbytes);
    logic [7:0] m [40];
    for (int k = 0; k < 40; k++) m[k] = '0;
    for (int k = 0; k < 4; k++) begin
      m[k]      = 8'(typ >> (8*k));
      m[4 + k]  = 8'(len >> (8*k));
      m[8 + k]  = 8'(id  >> (8*k));
      m[12 + k] = 8'(vec >> (8*k));
    end
    for (int k = 0; k < nbytes; k++) push_byte(m[k]);
  endtask

  task automatic connect(input int id, input int vec, input int len, input string tag);
    if (len < 16) exp_err(1, "R10");
    else if (id >= 16) exp_err(4, "R9");
    else begin
      if (id >= m_trk) m_trk = id + 1;
      if (vec != m_cnt[id])       exp_err(2, "R5");
      else if (m_cnt[id] >= LIM)  exp_err(3, "R6");
      else                        m_cnt[id]++;
    end
    send_msg(1, len, id, vec, len);
  endtask

  task automatic peer_gone(input int id, input int len);
    if (len < 12) exp_err(1, "R10");
    else if (id >= m_trk || id == OWN) exp_err(4, "R8");
    else begin
      m_cnt[id] = 0;
      exp_gone(id, "R7");
    end
    send_msg(2, len, id, 0, len);
  endtask

  task automatic check_cnt(input int id, input string tag);
    repeat (3) @(negedge clk);
    rd_peer = 4'(id);
    #1 check(rd_count == 11'(m_cnt[id]), tag, int'(rd_count), m_cnt[id]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_mis++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    check(!err && !gone, "R1 strobes", int'(err) + int'(gone), 0);
    check(rd_count == '0, "R1 count", int'(rd_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after release", int'(in_ready), 1);

    // R4: in-order registration, back to back
    connect(0, 0, 16, "R4");
    connect(0, 1, 16, "R4");
    check_cnt(0, "R4 count after two");
    // R5: repeated index
    connect(0, 0, 16, "R5");
    check_cnt(0, "R5 count unchanged");
    // R6: limit reached
    connect(0, 2, 16, "R4");
    connect(0, 3, 16, "R6");
    check_cnt(0, "R6 count at limit");
    connect(0, 5, 16, "R5");

    // R8/R9: range tracking
    peer_gone(5, 12);
    connect(5, 1, 16, "R9");
    peer_gone(2, 12);
    connect(5, 0, 16, "R9");
    check_cnt(5, "R9 grown peer count");
    peer_gone(5, 12);
    check_cnt(5, "R7 cleared grown peer");
    connect(16, 0, 16, "R9");
    connect(3, 0, 16, "R4");
    check_cnt(3, "R4 peer three");

    // R7: clear peer zero
    peer_gone(0, 12);
    check_cnt(0, "R7 cleared peer zero");
    connect(0, 0, 16, "R7");
    check_cnt(0, "R7 restart from zero");

    // R3/R10: lengths and exact consumption
    connect(1, 0, 12, "R10");
    connect(1, 0, 20, "R3");
    connect(1, 1, 32, "R3");
    check_cnt(1, "R3 padded lengths");
    peer_gone(1, 8);
    exp_err(1, "R10");
    send_msg(2, 4, 1, 0, 8);
    connect(1, 2, 16, "R3");
    check_cnt(1, "R10 short header realign");

    // R11: unknown type
    exp_err(5, "R11");
    send_msg(7, 12, 0, 0, 12);
    connect(4, 0, 16, "R11");
    check_cnt(4, "R11 next message intact");

    // R2/R10: oversized length fills buffer
    repeat (3) @(negedge clk);
    exp_err(1, "R10");
    send_msg(9, 40, 0, 0, 32);
    @(negedge clk);
    check(in_ready == 1'b0, "R2 ready low when full", int'(in_ready), 0);
    @(negedge clk);
    check(in_ready == 1'b1, "R2 ready after flush", int'(in_ready), 1);
    connect(4, 1, 16, "R2");
    check_cnt(4, "R2 after flush");
    check_cnt(1, "R5 untouched peer");

    repeat (6) @(negedge clk);
    check(sb.size() == 0, "R12 all events seen", sb.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule